// File: doc/BRIEF.md
# Private Peripheral Region Decoder

This block sits in front of the private peripheral space that up to four processor cores share. Each access carries an address, a write strobe, write data and the index of the core making it. Only the low 12 bits of the address are looked at. The 4 KB window is split into three kinds of target:

- a small snoop-control bank that lives inside this block;
- the per-core interrupt-controller interface;
- the per-core timer and watchdog pair.

Both the interrupt interface and the timers are reachable in two ways. A "self" alias resolves to the core that issued the access. A set of fixed per-core pages names a core outright.

Requests are registered. In the cycle after a request the block does three things. It raises exactly one target select, or an error flag, or nothing at all for an access to an absent core. It hands the selected target its local core or instance index and its local offset. It returns the read data chosen from the internal bank or from the target's read bus.

A two-state machine governs this:

- `ST_IDLE` means no access is in flight.
- `ST_ISSUE` is the single cycle in which a captured access is routed and answered.

The transitions are:

- `IDLE_TO_ISSUE` when `req_vld` is high in `ST_IDLE`.
- `ISSUE_TO_ISSUE` when another request arrives back to back.
- `ISSUE_TO_IDLE` when no request follows.
- `IDLE_HOLD` when the block stays idle.

Top module: `priv_region_decoder`

## Requirements
- R1: Address bits above bit 11 have no effect; only `req_addr[11:0]` (the offset) is decoded.
- R2: The control register at offset 0x000 keeps only bit 0 of the written data, reads it back zero-extended, and reads 0 after reset.
- R3: A read of offset 0x004 returns the present-core mask `(2^NUM_CPU - 1)` placed from bit 4 upward, ORed with `NUM_CPU - 1` in the low bits.
- R4: Offsets 0x008 and 0x00C read as 0. A write to 0x00C is accepted without error and changes no state.
- R5: Offsets 0x100–0x1FF select the interrupt interface of core `req_cpu`, with `gic_off = offset[7:0]`.
- R6: Offsets 0x200–0x5FF select the interrupt interface of core `(offset - 0x200) >> 8`, with `gic_off = offset[7:0]`.
- R7: Offsets 0x600–0x6FF select the timer pair of core `req_cpu`. Offsets 0x700–0xAFF select the pair of core `(offset - 0x700) >> 8`. In both cases `tmr_off = offset[3:0]`.
- R8: Inside a timer window, offset bit 5 picks the watchdog (1) or the timer (0). `tmr_idx = core*2 + bit5`, and `tmr_ppi` is 29 for the timer and 30 for the watchdog.
- R9: An access to a core index at or above `NUM_CPU` raises no select and no error, and reads 0.
- R10: Offsets 0xB00–0xFFF, reads of an undefined control-bank offset, and writes to 0x004, 0x008 or any undefined control-bank offset all do the same three things: raise `rsp_err` for exactly one cycle, read 0, and select no target.
- R11: `rsp_vld` and any select are high in exactly the cycle after each accepted request. Back-to-back requests are answered on consecutive cycles.
- R12: The read data comes from the selected target's read bus, from the control bank, or is 0. A write always returns 0. `tgt_wdata` carries the write data to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Access request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address; only the low 12 bits are decoded |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 2 | Index of the requesting core |
| gic_sel | output | 1 | Interrupt-interface select |
| gic_wr | output | 1 | Write strobe to the interrupt interface |
| gic_cpu | output | 2 | Core whose interrupt interface is addressed |
| gic_off | output | 8 | Local offset inside the interrupt interface |
| gic_rdata | input | 32 | Read data from the interrupt interface |
| tmr_sel | output | 1 | Timer-pair select |
| tmr_wr | output | 1 | Write strobe to the timer pair |
| tmr_idx | output | 3 | Instance index: core*2 + watchdog bit |
| tmr_off | output | 4 | Local register offset in the instance |
| tmr_ppi | output | 5 | Private interrupt line of the instance (29 or 30) |
| tmr_rdata | input | 32 | Read data from the timer pair |
| tgt_wdata | output | 32 | Write data forwarded to the target |
| rsp_vld | output | 1 | Response cycle |
| rsp_err | output | 1 | Access hit an undefined location |
| rsp_rdata | output | 32 | Read data |

## Verification
The bound checker covers the invariants that hold on every cycle:

- at most one of the two selects and the error flag is active at a time;
- a response follows each request by exactly one cycle, and no response appears without one;
- an error response and a write response both read zero;
- the interrupt line matches the instance index;
- a select never names a core at or above the configured count.

Only the directed scenarios can show the address map itself. These cover which core a self alias or a fixed page resolves to, the exact local offsets, the configuration value, the single-bit storage of the control register, the silent dropping of accesses to absent cores, and the independence from the upper address bits.

// File: rtl/priv_region_pkg.sv
package priv_region_pkg;

    localparam int OFF_W     = 12;
    localparam int DATA_W    = 32;
    localparam int MAX_CPU   = 4;
    localparam int CPU_W     = $clog2(MAX_CPU);
    localparam int TIDX_W    = CPU_W + 1;
    localparam int LOC_W     = 8;
    localparam int TOFF_W    = 4;
    localparam int PPI_W     = 5;
    localparam int PPI_TIMER = 29;
    localparam int PPI_WDOG  = 30;
    localparam int WDOG_BIT  = 5;
    localparam int PAGE_LSB  = 8;

    typedef enum logic [2:0] {
        RG_CTL,
        RG_ICU_SELF,
        RG_ICU_BANK,
        RG_TMR_SELF,
        RG_TMR_BANK,
        RG_NONE
    } region_e;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_CTL,
        SRC_ICU,
        SRC_TMR
    } src_e;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } state_e;

endpackage

// File: rtl/priv_region_classify.sv
module priv_region_classify
    import priv_region_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [OFF_W-1:0] off,
    input  logic [CPU_W-1:0] req_cpu,
    output region_e          region,
    output logic [CPU_W-1:0] cpu,
    output logic             in_range
);

    localparam logic [OFF_W-1:0] ICU_SELF_BASE = 12'h100;
    localparam logic [OFF_W-1:0] ICU_BANK_BASE = 12'h200;
    localparam logic [OFF_W-1:0] TMR_SELF_BASE = 12'h600;
    localparam logic [OFF_W-1:0] TMR_BANK_BASE = 12'h700;
    localparam logic [OFF_W-1:0] REGION_LIMIT  = 12'hB00;

    logic [OFF_W-1:0] icu_rel;
    logic [OFF_W-1:0] tmr_rel;

    assign icu_rel = off - ICU_BANK_BASE;
    assign tmr_rel = off - TMR_BANK_BASE;

    always_comb begin
        region = RG_NONE;
        cpu    = req_cpu;
        if (off < ICU_SELF_BASE) begin
            region = RG_CTL;
        end else if (off < ICU_BANK_BASE) begin
            region = RG_ICU_SELF;
        end else if (off < TMR_SELF_BASE) begin
            region = RG_ICU_BANK;
            cpu    = CPU_W'(icu_rel >> PAGE_LSB);
        end else if (off < TMR_BANK_BASE) begin
            region = RG_TMR_SELF;
        end else if (off < REGION_LIMIT) begin
            region = RG_TMR_BANK;
            cpu    = CPU_W'(tmr_rel >> PAGE_LSB);
        end
    end

    assign in_range = int'(cpu) < NUM_CPU;

endmodule

// File: rtl/priv_region_ctl_bank.sv
module priv_region_ctl_bank
    import priv_region_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [LOC_W-1:0]  off,
    input  logic              wbit,
    output logic [DATA_W-1:0] rdata,
    output logic              bad
);

    localparam logic [LOC_W-1:0] CTL_OFF = 8'h00;
    localparam logic [LOC_W-1:0] CFG_OFF = 8'h04;
    localparam logic [LOC_W-1:0] STS_OFF = 8'h08;
    localparam logic [LOC_W-1:0] INV_OFF = 8'h0C;
    localparam int               MASK_LSB = 4;
    localparam logic [DATA_W-1:0] CFG_VAL =
        DATA_W'(((1 << NUM_CPU) - 1) << MASK_LSB) | DATA_W'(NUM_CPU - 1);

    logic ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= 1'b0;
        end else if (acc && wr && off == CTL_OFF) begin
            ctl_q <= wbit;
        end
    end

    always_comb begin
        rdata = '0;
        bad   = 1'b0;
        unique case (off)
            CTL_OFF: rdata = DATA_W'(ctl_q);
            CFG_OFF: begin
                rdata = CFG_VAL;
                bad   = wr;
            end
            STS_OFF: bad = wr;
            INV_OFF: bad = 1'b0;
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/priv_region_rdmux.sv
module priv_region_rdmux
    import priv_region_pkg::*;
(
    input  src_e              src,
    input  logic [DATA_W-1:0] ctl_data,
    input  logic [DATA_W-1:0] icu_data,
    input  logic [DATA_W-1:0] tmr_data,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (src)
            SRC_CTL:  rdata = ctl_data;
            SRC_ICU:  rdata = icu_data;
            SRC_TMR:  rdata = tmr_data;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/priv_region_decoder.sv
module priv_region_decoder
    import priv_region_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CPU_W-1:0]  req_cpu,
    output logic              gic_sel,
    output logic              gic_wr,
    output logic [CPU_W-1:0]  gic_cpu,
    output logic [LOC_W-1:0]  gic_off,
    input  logic [DATA_W-1:0] gic_rdata,
    output logic              tmr_sel,
    output logic              tmr_wr,
    output logic [TIDX_W-1:0] tmr_idx,
    output logic [TOFF_W-1:0] tmr_off,
    output logic [PPI_W-1:0]  tmr_ppi,
    input  logic [DATA_W-1:0] tmr_rdata,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              rsp_vld,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    state_e            state_q;
    state_e            state_d;
    logic [OFF_W-1:0]  stg_off;
    logic              stg_wr;
    logic [DATA_W-1:0] stg_wdata;
    logic [CPU_W-1:0]  stg_cpu;

    region_e           region;
    logic [CPU_W-1:0]  cls_cpu;
    logic              cls_in_range;
    logic              ctl_acc;
    logic [DATA_W-1:0] ctl_rdata;
    logic              ctl_bad;
    src_e              src;

    logic              unused_addr_hi;
    assign unused_addr_hi = ^req_addr[ADDR_W-1:OFF_W];

    // Request stage capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_off   <= '0;
            stg_wr    <= 1'b0;
            stg_wdata <= '0;
            stg_cpu   <= '0;
        end else if (req_vld) begin
            stg_off   <= req_addr[OFF_W-1:0];
            stg_wr    <= req_wr;
            stg_wdata <= req_wdata;
            stg_cpu   <= req_cpu;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_vld ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = req_vld ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    priv_region_classify #(
        .NUM_CPU (NUM_CPU)
    ) u_classify (
        .off      (stg_off),
        .req_cpu  (stg_cpu),
        .region   (region),
        .cpu      (cls_cpu),
        .in_range (cls_in_range)
    );

    priv_region_ctl_bank #(
        .NUM_CPU (NUM_CPU)
    ) u_ctl_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (ctl_acc),
        .wr    (stg_wr),
        .off   (stg_off[LOC_W-1:0]),
        .wbit  (stg_wdata[0]),
        .rdata (ctl_rdata),
        .bad   (ctl_bad)
    );

    // Output logic
    always_comb begin
        rsp_vld = 1'b0;
        rsp_err = 1'b0;
        gic_sel = 1'b0;
        gic_wr  = 1'b0;
        tmr_sel = 1'b0;
        tmr_wr  = 1'b0;
        ctl_acc = 1'b0;
        src     = SRC_ZERO;
        unique case (state_q)
            ST_IDLE: begin
                rsp_vld = 1'b0;
            end
            ST_ISSUE: begin
                rsp_vld = 1'b1;
                unique case (region)
                    RG_CTL: begin
                        ctl_acc = 1'b1;
                        rsp_err = ctl_bad;
                        src     = (ctl_bad || stg_wr) ? SRC_ZERO : SRC_CTL;
                    end
                    RG_ICU_SELF, RG_ICU_BANK: begin
                        if (cls_in_range) begin
                            gic_sel = 1'b1;
                            gic_wr  = stg_wr;
                            src     = stg_wr ? SRC_ZERO : SRC_ICU;
                        end
                    end
                    RG_TMR_SELF, RG_TMR_BANK: begin
                        if (cls_in_range) begin
                            tmr_sel = 1'b1;
                            tmr_wr  = stg_wr;
                            src     = stg_wr ? SRC_ZERO : SRC_TMR;
                        end
                    end
                    default: begin
                        rsp_err = 1'b1;
                    end
                endcase
            end
            default: begin
                rsp_vld = 1'b0;
            end
        endcase
    end

    assign gic_cpu   = cls_cpu;
    assign gic_off   = stg_off[LOC_W-1:0];
    assign tmr_idx   = {cls_cpu, stg_off[WDOG_BIT]};
    assign tmr_off   = stg_off[TOFF_W-1:0];
    assign tmr_ppi   = stg_off[WDOG_BIT] ? PPI_W'(PPI_WDOG) : PPI_W'(PPI_TIMER);
    assign tgt_wdata = stg_wdata;

    priv_region_rdmux u_rdmux (
        .src      (src),
        .ctl_data (ctl_rdata),
        .icu_data (gic_rdata),
        .tmr_data (tmr_rdata),
        .rdata    (rsp_rdata)
    );

endmodule

// File: rtl/priv_region_decoder_chk.sv
module priv_region_decoder_chk
    import priv_region_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_wr,
    input logic              gic_sel,
    input logic [CPU_W-1:0]  gic_cpu,
    input logic              tmr_sel,
    input logic [TIDX_W-1:0] tmr_idx,
    input logic [PPI_W-1:0]  tmr_ppi,
    input logic              rsp_vld,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata
);

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gic_sel, tmr_sel, rsp_err})); // R10

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == '0); // R10

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld); // R11

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld); // R11

    AST_SEL_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (gic_sel || tmr_sel || rsp_err) |-> rsp_vld); // R11

    AST_PPI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_sel |-> (tmr_ppi == (tmr_idx[0] ? PPI_W'(PPI_WDOG) : PPI_W'(PPI_TIMER)))); // R8

    AST_GIC_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        gic_sel |-> int'(gic_cpu) < NUM_CPU); // R9

    AST_TMR_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_sel |-> int'(tmr_idx) < 2 * NUM_CPU); // R9

    AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_wr) |=> rsp_rdata == '0); // R12

endmodule

bind priv_region_decoder priv_region_decoder_chk #(.NUM_CPU(NUM_CPU)) u_chk (.*);

// File: tb/priv_region_decoder_test.sv
module priv_region_decoder_test;
    import priv_region_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_CPU      = 3;
    localparam int WDOG_LIMIT = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_vld = 1'b0;
    logic              req_wr = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [1:0]        req_cpu = '0;
    logic              gic_sel, gic_wr, tmr_sel, tmr_wr, rsp_vld, rsp_err;
    logic [1:0]        gic_cpu;
    logic [7:0]        gic_off;
    logic [2:0]        tmr_idx;
    logic [3:0]        tmr_off;
    logic [4:0]        tmr_ppi;
    logic [31:0]       gic_rdata, tmr_rdata, tgt_wdata, rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Target stubs: read data encodes the index and offset they were given
    assign gic_rdata = {16'hC1C0, 6'd0, gic_cpu, gic_off};
    assign tmr_rdata = {16'hD1D0, 9'd0, tmr_idx, tmr_off};

    priv_region_decoder #(.ADDR_W(32), .NUM_CPU(N_CPU)) uut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
        .gic_sel(gic_sel), .gic_wr(gic_wr), .gic_cpu(gic_cpu), .gic_off(gic_off),
        .gic_rdata(gic_rdata), .tmr_sel(tmr_sel), .tmr_wr(tmr_wr),
        .tmr_idx(tmr_idx), .tmr_off(tmr_off), .tmr_ppi(tmr_ppi),
        .tmr_rdata(tmr_rdata), .tgt_wdata(tgt_wdata), .rsp_vld(rsp_vld),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] gic_pat(input logic [1:0] c, input logic [7:0] o);
        return {16'hC1C0, 6'd0, c, o};
    endfunction

    function automatic logic [31:0] tmr_pat(input logic [2:0] i, input logic [3:0] o);
        return {16'hD1D0, 9'd0, i, o};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return with outputs of the issue cycle stable
    task automatic issue(input logic wr, input logic [31:0] addr,
                         input logic [31:0] wdata, input logic [1:0] cpu);
        @(negedge clk);
        req_vld   = 1'b1;
        req_wr    = wr;
        req_addr  = addr;
        req_wdata = wdata;
        req_cpu   = cpu;
        @(negedge clk);
        req_vld   = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 idle after reset rsp_vld", 32'(rsp_vld), 32'd0);
        check("R11 idle after reset selects", 32'({gic_sel, tmr_sel, rsp_err}), 32'd0);
        issue(1'b0, 32'h0000_0000, '0, 2'd0);
        check("R2 control reads 0 after reset", rsp_rdata, 32'd0);
        check("R11 response valid", 32'(rsp_vld), 32'd1);
    endtask

    task automatic t_control();
        issue(1'b1, 32'h0000_0000, 32'hFFFF_FFFE, 2'd0);
        check("R12 write returns zero", rsp_rdata, 32'd0);
        issue(1'b0, 32'h0000_0000, '0, 2'd0);
        check("R2 bit0 only stored (0)", rsp_rdata, 32'd0);
        issue(1'b1, 32'h0000_0000, 32'h0000_0003, 2'd0);
        issue(1'b0, 32'hABCD_E000, '0, 2'd0);
        check("R2 bit0 only stored (1)", rsp_rdata, 32'd1);
        check("R1 upper address ignored on control", 32'(rsp_err), 32'd0);
    endtask

    task automatic t_config();
        issue(1'b0, 32'h0000_0004, '0, 2'd1);
        check("R3 configuration value", rsp_rdata, 32'h0000_0072);
        issue(1'b1, 32'h0000_0004, 32'h1234_5678, 2'd1);
        check("R10 write to configuration errors", 32'(rsp_err), 32'd1);
    endtask

    task automatic t_zero_regs();
        issue(1'b0, 32'h0000_0008, '0, 2'd0);
        check("R4 status reads 0", rsp_rdata, 32'd0);
        issue(1'b0, 32'h0000_000C, '0, 2'd0);
        check("R4 invalidate reads 0", rsp_rdata, 32'd0);
        issue(1'b1, 32'h0000_000C, 32'h0000_0000, 2'd0);
        check("R4 invalidate write no error", 32'(rsp_err), 32'd0);
        issue(1'b0, 32'h0000_0000, '0, 2'd0);
        check("R4 invalidate write leaves control", rsp_rdata, 32'd1);
    endtask

    task automatic t_icu();
        issue(1'b0, 32'h5555_51A4, '0, 2'd1);
        check("R5 alias selects interface", 32'(gic_sel), 32'd1);
        check("R5 alias read data core1 off A4", rsp_rdata, gic_pat(2'd1, 8'hA4));
        check("R1 upper bits ignored on alias", 32'(rsp_err), 32'd0);
        issue(1'b0, 32'h0000_0310, '0, 2'd0);
        check("R6 page 0x300 -> core1 off 10", rsp_rdata, gic_pat(2'd1, 8'h10));
        issue(1'b0, 32'h0000_02FF, '0, 2'd2);
        check("R6 page 0x200 -> core0 off FF", rsp_rdata, gic_pat(2'd0, 8'hFF));
        issue(1'b1, 32'h0000_0420, 32'hCAFE_0042, 2'd0);
        check("R12 interface write strobe", 32'({gic_sel, gic_wr, tmr_sel}), 32'b110);
        check("R6 write core2 off 20", 32'({gic_cpu, gic_off}), 32'({2'd2, 8'h20}));
        check("R12 write data forwarded", tgt_wdata, 32'hCAFE_0042);
        check("R12 write reads zero", rsp_rdata, 32'd0);
    endtask

    task automatic t_timers();
        issue(1'b0, 32'h0000_0628, '0, 2'd2);
        check("R7 self timer alias core2 watchdog", rsp_rdata, tmr_pat(3'd5, 4'h8));
        check("R8 watchdog line 30", 32'(tmr_ppi), 32'd30);
        issue(1'b0, 32'h0000_090C, '0, 2'd0);
        check("R7 page 0x900 -> core2 timer", rsp_rdata, tmr_pat(3'd4, 4'hC));
        check("R8 timer line 29", 32'(tmr_ppi), 32'd29);
        issue(1'b1, 32'h0000_0704, 32'h0000_0100, 2'd1);
        check("R7 write core0 timer", 32'({tmr_sel, tmr_wr, tmr_idx, tmr_off}),
              32'({1'b1, 1'b1, 3'd0, 4'h4}));
    endtask

    task automatic t_absent_core();
        issue(1'b0, 32'h0000_0500, '0, 2'd0);
        check("R9 absent core page no select", 32'({gic_sel, tmr_sel, rsp_err}), 32'd0);
        check("R9 absent core reads zero", rsp_rdata, 32'd0);
        issue(1'b1, 32'h0000_0A20, 32'hFFFF_FFFF, 2'd0);
        check("R9 absent timer write dropped", 32'({gic_sel, tmr_sel, rsp_err}), 32'd0);
        issue(1'b0, 32'h0000_0104, '0, 2'd3);
        check("R9 absent requester alias dropped", 32'({gic_sel, tmr_sel, rsp_err}), 32'd0);
        check("R9 absent requester reads zero", rsp_rdata, 32'd0);
    endtask

    task automatic t_errors();
        issue(1'b0, 32'h0000_0B00, '0, 2'd0);
        check("R10 beyond map errors", 32'({gic_sel, tmr_sel, rsp_err}), 32'd1);
        check("R10 error reads zero", rsp_rdata, 32'd0);
        @(negedge clk);
        check("R10 error lasts one cycle", 32'({rsp_err, rsp_vld}), 32'd0);
        issue(1'b0, 32'h0000_0FFC, '0, 2'd1);
        check("R10 top of map errors", 32'(rsp_err), 32'd1);
        issue(1'b0, 32'h0000_0010, '0, 2'd0);
        check("R10 undefined control offset errors", 32'(rsp_err), 32'd1);
        check("R10 undefined control reads zero", rsp_rdata, 32'd0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b0; req_addr = 32'h0000_0204; req_cpu = 2'd2;
        @(negedge clk);
        check("R11 first of pair valid", 32'(rsp_vld), 32'd1);
        check("R11 first of pair data", rsp_rdata, gic_pat(2'd0, 8'h04));
        req_addr = 32'h0000_0738;
        @(negedge clk);
        req_vld = 1'b0;
        check("R11 second of pair valid", 32'(rsp_vld), 32'd1);
        check("R11 second of pair data", rsp_rdata, tmr_pat(3'd1, 4'h8));
        @(negedge clk);
        check("R11 idle after pair", 32'(rsp_vld), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_control();
        t_config();
        t_zero_regs();
        t_icu();
        t_timers();
        t_absent_core();
        t_errors();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule